// File: doc/BRIEF.md
# Programmable Clock Divider and Router

This block derives clocks from a single reference. A counter divides the reference by a 6-bit ratio P that may be odd or even. A separate toggle stage produces the reference halved. A router places the reference, the halved clock or the divided clock on the main clock output.

A shared multi-purpose pin has three roles. It can be an output-enable input that tri-states the main output. It can be a power-down input that freezes every counter and silences both outputs. It can be a second clock output that carries the reference, the halved clock or a copy of the main output.

Every configuration field is a static register input. Tri-state is modelled by an enable that goes with each clock output. The level on the pin passes through a synchronizer before it is used. The divided clock keeps a 50 percent duty cycle for odd ratios as well as even ones. It does this by combining a rising-edge waveform with a copy delayed by half a reference cycle.

Top module: `clkdiv_router`

## Requirements
- R1: For an effective ratio P from 2 to 63, odd or even, every high phase and every low phase of the divided clock lasts exactly P half-cycles of the reference, giving a 50 percent duty cycle.
- R2: A ratio of 1 passes the reference through unchanged, and a ratio of 0 acts as a ratio of 1.
- R3: `cfg_main_sel` routes a source to `clk_main`: code 0 selects the reference, code 1 selects the halved clock, and codes 2 and 3 select the divided clock.
- R4: The halved clock stays high for one full reference cycle and then low for one full reference cycle.
- R5: `cfg_pin_mode` sets the role of the shared pin: code 0 is output-enable input, code 1 is power-down input, and codes 2 and 3 make it a clock output. Only in the clock-output role is `clk_aux_en` high. In that role, `cfg_aux_sel` code 0 selects the reference, code 1 selects the halved clock, and codes 2 and 3 select a copy of `clk_main`. In the two input roles `clk_aux` stays low.
- R6: In output-enable mode, a low level on `pin_in` drops `clk_main_en` within five reference cycles while the divider keeps running. A high level restores the enable.
- R7: In power-down mode, a low level on `pin_in` raises `sleep` within six reference cycles, clears the counters and holds both clock outputs low, whatever source is selected.
- R8: A new ratio is adopted only at the terminal count of the current period. Across the changeover, each phase lasts between min(Pold,Pnew)-1 and max(Pold,Pnew)+1 half-cycles. After the changeover, every phase is Pnew half-cycles long.
- R9: On release from power-down, the divider starts from zero. The divided clock stays low for at least P half-cycles. A ratio written during sleep applies from the first period.
- R10: While `rst_n` is low, `sleep` is low, `clk_main_en` is high, `clk_aux_en` is low, and a main output routed to the divided clock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ratio | input | RATIO_W | Divide ratio P (0 acts as 1) |
| cfg_main_sel | input | 2 | Main output source code |
| cfg_pin_mode | input | 2 | Role of the shared pin |
| cfg_aux_sel | input | 2 | Second output source code |
| pin_in | input | 1 | Level on the shared pin when it is an input, 1 when undriven |
| clk_main | output | 1 | Main clock output |
| clk_main_en | output | 1 | Drive enable of the main output (0 = tri-state) |
| clk_aux | output | 1 | Second clock output |
| clk_aux_en | output | 1 | Drive enable of the second output |
| sleep | output | 1 | High while powered down |

## Verification
A ratio change and a wake from power-down can land in the same cycle. The divider reloads its ratio both at terminal count and on the first cycle after sleep. The bench provokes this by writing a new ratio while the block is asleep and then releasing the pin. It then judges the result from the phase lengths it samples. The first low phase must last at least the new P half-cycles, and every later phase must equal the new P rather than the old one. Changes made during running are also timed to fall mid-period, so that the terminal-count reload overlaps odd/even waveform switching.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MSRC_REF     = 2'd0,
    MSRC_HALF    = 2'd1,
    MSRC_DIV     = 2'd2,
    MSRC_DIV_ALT = 2'd3
  } main_src_e;

  typedef enum logic [1:0] {
    PIN_OE      = 2'd0,
    PIN_PD      = 2'd1,
    PIN_CLK     = 2'd2,
    PIN_CLK_ALT = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    ASRC_REF      = 2'd0,
    ASRC_HALF     = 2'd1,
    ASRC_MAIN     = 2'd2,
    ASRC_MAIN_ALT = 2'd3
  } aux_src_e;
endpackage

// File: rtl/clkdiv_sync.sv
`timescale 1ns/1ps
module clkdiv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stg_d[g] = d;
    end else begin : g_tail
      assign stg_d[g] = stg_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] ratio_cfg,
  output logic         ref_gated,
  output logic         half_clk,
  output logic         div_clk
);
  logic         armed_q;
  logic         live;
  logic         term;
  logic [W-1:0] ratio_eff;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] ratio_q, ratio_d;
  logic [W:0]   thr;
  logic         pos_q, pos_d;
  logic         neg_q;
  logic         half_q, half_d;

  assign ratio_eff = (ratio_cfg == '0) ? W'(1) : ratio_cfg;
  assign live      = run & armed_q;
  assign term      = (cnt_q == ratio_q - W'(1));

  // next state: counter, ratio reload at wrap, rising-edge waveform
  always_comb begin
    if (!live) begin
      cnt_d   = '0;
      ratio_d = ratio_eff;
      half_d  = 1'b0;
    end else begin
      half_d = ~half_q;
      if (term) begin
        cnt_d   = '0;
        ratio_d = ratio_eff;
      end else begin
        cnt_d   = cnt_q + W'(1);
        ratio_d = ratio_q;
      end
    end
    thr   = ({1'b0, ratio_d} + (W+1)'(1)) >> 1;
    pos_d = live && ({1'b0, cnt_d} >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= W'(1);
      pos_q   <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      pos_q   <= pos_d;
      half_q  <= half_d;
    end
  end

  // half-cycle delayed copy, used only for odd ratios
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q & ratio_q[0] & live;
  end

  assign ref_gated = clk & live;
  assign half_clk  = half_q;
  assign div_clk   = (ratio_q == W'(1)) ? ref_gated : (pos_q | neg_q);

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q); // R1
  AST_RATIO_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> (cnt_q == '0)); // R8
  AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(live) |-> (half_q != $past(half_q))); // R4
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (cnt_q == '0 && !pos_q && !half_q)); // R7
endmodule

// File: rtl/clkdiv_route.sv
`timescale 1ns/1ps
module clkdiv_route
  import clkdiv_pkg::*;
(
  input  logic       ref_gated,
  input  logic       half_clk,
  input  logic       div_clk,
  input  logic [1:0] main_sel,
  input  logic [1:0] aux_sel,
  input  logic [1:0] pin_mode,
  input  logic       pin_lvl,
  output logic       main_clk,
  output logic       main_en,
  output logic       aux_clk,
  output logic       aux_en
);
  pin_mode_e mode;
  logic      aux_src;

  assign mode = pin_mode_e'(pin_mode);

  always_comb begin
    case (main_src_e'(main_sel))
      MSRC_REF:  main_clk = ref_gated;
      MSRC_HALF: main_clk = half_clk;
      default:   main_clk = div_clk;
    endcase
    case (aux_src_e'(aux_sel))
      ASRC_REF:  aux_src = ref_gated;
      ASRC_HALF: aux_src = half_clk;
      default:   aux_src = main_clk;
    endcase
    aux_en  = (mode == PIN_CLK) || (mode == PIN_CLK_ALT);
    aux_clk = aux_en & aux_src;
    main_en = !((mode == PIN_OE) && !pin_lvl);
  end
endmodule

// File: rtl/clkdiv_router.sv
`timescale 1ns/1ps
module clkdiv_router
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [1:0]         cfg_main_sel,
  input  logic [1:0]         cfg_pin_mode,
  input  logic [1:0]         cfg_aux_sel,
  input  logic               pin_in,
  output logic               clk_main,
  output logic               clk_main_en,
  output logic               clk_aux,
  output logic               clk_aux_en,
  output logic               sleep
);
  logic rst_sync_n;
  logic pin_lvl;
  logic sleep_q, sleep_d;
  logic ref_gated, half_clk, div_clk;

  clkdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  clkdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(pin_in), .q(pin_lvl)
  );

  always_comb begin
    sleep_d = (pin_mode_e'(cfg_pin_mode) == PIN_PD) && !pin_lvl;
  end

  always_ff @(posedge ref_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sleep_q <= 1'b0;
    else             sleep_q <= sleep_d;
  end

  clkdiv_core #(.W(RATIO_W)) u_core (
    .clk(ref_clk), .rst_n(rst_sync_n), .run(!sleep_q), .ratio_cfg(cfg_ratio),
    .ref_gated(ref_gated), .half_clk(half_clk), .div_clk(div_clk)
  );

  clkdiv_route u_route (
    .ref_gated(ref_gated), .half_clk(half_clk), .div_clk(div_clk),
    .main_sel(cfg_main_sel), .aux_sel(cfg_aux_sel), .pin_mode(cfg_pin_mode),
    .pin_lvl(pin_lvl), .main_clk(clk_main), .main_en(clk_main_en),
    .aux_clk(clk_aux), .aux_en(clk_aux_en)
  );

  assign sleep = sleep_q;

  AST_QUIET_ASLEEP: assert property (@(posedge ref_clk) disable iff (!rst_sync_n)
    (sleep_q && $past(sleep_q)) |-> (!clk_main && !clk_aux)); // R7
  AST_OE_GATES: assert property (@(posedge ref_clk) disable iff (!rst_sync_n)
    (cfg_pin_mode == 2'd0 && $past(cfg_pin_mode) == 2'd0 && !pin_lvl && $past(!pin_lvl))
      |-> !clk_main_en); // R6
  AST_AUX_QUIET_INPUT: assert property (@(posedge ref_clk) disable iff (!rst_sync_n)
    !cfg_pin_mode[1] |-> (!clk_aux_en && !clk_aux)); // R5
endmodule

// File: tb/clkdiv_router_tb.sv
`timescale 1ns/1ps
module clkdiv_router_tb;
  localparam int RW = 6;

  logic          ref_clk, rst_n;
  logic [RW-1:0] cfg_ratio;
  logic [1:0]    cfg_main_sel, cfg_pin_mode, cfg_aux_sel;
  logic          pin_in;
  logic          clk_main, clk_main_en, clk_aux, clk_aux_en, sleep;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  bit smp [0:2047];

  clkdiv_router #(.RATIO_W(RW)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio),
    .cfg_main_sel(cfg_main_sel), .cfg_pin_mode(cfg_pin_mode),
    .cfg_aux_sel(cfg_aux_sel), .pin_in(pin_in), .clk_main(clk_main),
    .clk_main_en(clk_main_en), .clk_aux(clk_aux), .clk_aux_en(clk_aux_en),
    .sleep(sleep)
  );

  initial begin
    ref_clk = 1'b0;
    forever #5 ref_clk = ~ref_clk;
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_ratio(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  // one sample in the high phase and one in the low phase of each reference cycle
  task automatic grab(input int ncyc, input bit use_aux);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge ref_clk); #2;
      smp[2*i] = use_aux ? clk_aux : clk_main;
      @(negedge ref_clk); #2;
      smp[2*i+1] = use_aux ? clk_aux : clk_main;
    end
  endtask

  // complete phases (first and last are partial and skipped) must lie in [lo,hi]
  task automatic check_runs(input int nh, input int lo, input int hi, input string req);
    int len, runs, bad_len;
    bit bad, first;
    len = 1; runs = 0; bad = 0; first = 1; bad_len = 0;
    for (int i = 1; i < nh; i++) begin
      if (smp[i] != smp[i-1]) begin
        if (!first) begin
          runs++;
          if ((len < lo || len > hi) && !bad) begin bad = 1; bad_len = len; end
        end
        first = 0;
        len = 1;
      end else begin
        len++;
      end
    end
    if (runs < 2) check(1'b0, req, runs, 2);
    else          check(!bad, req, bad ? bad_len : lo, lo);
  endtask

  function automatic int count_ones(input int nh);
    int c = 0;
    for (int i = 0; i < nh; i++) c += int'(smp[i]);
    return c;
  endfunction

  function automatic int lead_zeros(input int nh);
    for (int i = 0; i < nh; i++) if (smp[i]) return i;
    return nh;
  endfunction

  task automatic sweep_ratio(input int p);
    int e;
    e = eff_ratio(p);
    cfg_ratio = RW'(p);
    wait_cyc(140);
    grab(6*e + 6, 1'b0);
    if (e == 1) check_runs(2*(6*e+6), 1, 1, "R2 ratio 0/1 passthrough");
    else        check_runs(2*(6*e+6), e, e, "R1 divided phase length");
  endtask

  task automatic change_ratio(input int a, input int b);
    int lo, hi, n;
    cfg_ratio = RW'(a);
    wait_cyc(140);
    lo = ((a < b) ? a : b) - 1;
    hi = ((a > b) ? a : b) + 1;
    n  = 4*(a+b) + 40;
    fork
      grab(n, 1'b0);
      begin
        repeat (a + 3) @(posedge ref_clk);
        #1 cfg_ratio = RW'(b);
      end
    join
    check_runs(2*n, lo, hi, "R8 no runt across change");
    grab(6*b + 6, 1'b0);
    check_runs(2*(6*b+6), b, b, "R8 new ratio after change");
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    int unsigned seed_v;
    int a, b, p;
    seed_v = $urandom(32'd610);
    rst_n = 1'b0; cfg_ratio = RW'(4); cfg_main_sel = 2'd2;
    cfg_pin_mode = 2'd0; cfg_aux_sel = 2'd0; pin_in = 1'b1;

    // R10 reset state
    wait_cyc(3);
    @(posedge ref_clk); #2;
    check(clk_main == 1'b0, "R10 main low in reset (high phase)", int'(clk_main), 0);
    check(sleep == 1'b0, "R10 sleep low in reset", int'(sleep), 0);
    check(clk_main_en == 1'b1, "R10 main enabled in reset", int'(clk_main_en), 1);
    check(clk_aux_en == 1'b0, "R10 aux disabled in reset", int'(clk_aux_en), 0);
    @(negedge ref_clk); #2;
    check(clk_main == 1'b0, "R10 main low in reset (low phase)", int'(clk_main), 0);
    @(posedge ref_clk); #1 rst_n = 1'b1;

    // R1 / R2 directed and random ratios
    sweep_ratio(2); sweep_ratio(3); sweep_ratio(4); sweep_ratio(5);
    sweep_ratio(63); sweep_ratio(1); sweep_ratio(0);
    for (int i = 0; i < 6; i++) begin
      p = int'($urandom_range(63, 2));
      sweep_ratio(p);
    end

    // R3 / R4 main source selection
    cfg_ratio = RW'(5);
    cfg_main_sel = 2'd0; wait_cyc(80); grab(40, 1'b0);
    check_runs(80, 1, 1, "R3 main code 0 reference");
    cfg_main_sel = 2'd1; wait_cyc(4); grab(40, 1'b0);
    check_runs(80, 2, 2, "R4 R3 main code 1 halved");
    cfg_main_sel = 2'd3; wait_cyc(4); grab(40, 1'b0);
    check_runs(80, 5, 5, "R3 main code 3 divided");
    cfg_main_sel = 2'd2;

    // R5 shared pin as clock output
    cfg_pin_mode = 2'd2; cfg_aux_sel = 2'd0; wait_cyc(4);
    check(clk_aux_en == 1'b1, "R5 aux enabled in clock role", int'(clk_aux_en), 1);
    grab(40, 1'b1); check_runs(80, 1, 1, "R5 aux code 0 reference");
    cfg_aux_sel = 2'd1; wait_cyc(4); grab(40, 1'b1);
    check_runs(80, 2, 2, "R5 aux code 1 halved");
    cfg_ratio = RW'(7); cfg_aux_sel = 2'd2; wait_cyc(40); grab(60, 1'b1);
    check_runs(120, 7, 7, "R5 aux code 2 main copy");
    cfg_pin_mode = 2'd1; pin_in = 1'b1; wait_cyc(4);
    check(clk_aux_en == 1'b0, "R5 aux disabled in input role", int'(clk_aux_en), 0);
    grab(40, 1'b1);
    check(count_ones(80) == 0, "R5 aux quiet in input role", count_ones(80), 0);

    // R6 output enable
    cfg_pin_mode = 2'd0; pin_in = 1'b0; wait_cyc(5);
    check(clk_main_en == 1'b0, "R6 OE low disables main", int'(clk_main_en), 1'b0);
    grab(60, 1'b0); check_runs(120, 7, 7, "R6 divider runs while disabled");
    pin_in = 1'b1; wait_cyc(5);
    check(clk_main_en == 1'b1, "R6 OE high enables main", int'(clk_main_en), 1);

    // R7 power-down, R9 wake with a ratio written during sleep
    cfg_main_sel = 2'd0; cfg_pin_mode = 2'd1; pin_in = 1'b0; wait_cyc(6);
    check(sleep == 1'b1, "R7 sleep raised", int'(sleep), 1);
    grab(40, 1'b0);
    check(count_ones(80) == 0, "R7 main quiet asleep", count_ones(80), 0);
    cfg_ratio = RW'(9); cfg_main_sel = 2'd2; wait_cyc(3);
    pin_in = 1'b1;
    grab(80, 1'b0);
    check(lead_zeros(160) >= 9, "R9 starts low after wake", lead_zeros(160), 9);
    check_runs(160, 9, 9, "R9 new ratio from first period");
    check(sleep == 1'b0, "R7 sleep cleared", int'(sleep), 0);

    // R8 ratio changes while running
    cfg_pin_mode = 2'd0;
    change_ratio(6, 11);
    change_ratio(9, 4);
    for (int i = 0; i < 4; i++) begin
      a = int'($urandom_range(63, 2));
      b = int'($urandom_range(63, 2));
      change_ratio(a, b);
    end

    done = 1;
    report();
  end
endmodule